// File: doc/BRIEF.md
# Option-ROM Base Address Register with Range Decode

This block holds the base register through which system software places a device's option ROM in the 32-bit memory map, and it decides which incoming memory requests fall in that window. The register has three parts. Its top bits are a base field that software can write. Below that field, a run of bits is hardwired to zero, and the length of that run marks the ROM size. Bit 0 is a decode switch that software sets and clears. To size the ROM, software writes all-ones and reads the register back. The lowest set bit at or above bit 11 gives log2 of the size in bytes. When the ROM is absent, the whole register reads zero.

A request is claimed only when four things hold: it is a memory read, its upper 32 address bits are zero, its address lies inside the programmed window, and both enables are on. The two enables are the register's own decode bit and the Memory Space Enable input. Each request gets exactly one answer one clock later: either a ROM hit or an unclaimed flag. A small response state machine carries that answer. It has three states. RSP_IDLE means no request was seen. RSP_HIT means the last request was claimed. RSP_MISS means the last request was not claimed. Every cycle, the machine moves to RSP_HIT on a claimed request, to RSP_MISS on an unclaimed one, and to RSP_IDLE when no request is presented, whatever its current state.

Top module: `exp_rom_bar`

## Requirements
- R1: After reset, `cfg_rdata` reads 0 and both `rom_hit` and `req_unclaimed` are 0.
- R2: Bits [10:1] of `cfg_rdata` always read 0. The bits from 11 up to log2(ROM_BYTES)-1 also read 0 whatever is written. With the default 64 KB, writing FFFF_FFFFh reads back FFFF_0001h.
- R3: Bit 0 of the register is the decode enable. A configuration write stores it, and it is visible in `cfg_rdata[0]` after the next clock edge.
- R4: Bits [31:log2(ROM_BYTES)] store the written base and read back unchanged.
- R5: A memory read (`req_is_write`=0) is claimed when all of these hold: its address has bits [63:32] zero, bits [31:log2(ROM_BYTES)] equal the stored base, bit 0 is set, and `mem_space_en` is 1. A claimed read raises `rom_hit` for exactly one cycle, on the clock after the request.
- R6: When bit 0 of the register is clear, no request is claimed, even with a base programmed.
- R7: When `mem_space_en` is 0, no request is claimed.
- R8: A request with any of address bits [63:32] set is never claimed.
- R9: A memory write (`req_is_write`=1) into the window is not claimed. It is reported by `req_unclaimed`.
- R10: Addresses one byte below the base and one byte past base+size-1 are not claimed. Base and base+size-1 are claimed.
- R11: With ROM_BYTES = 0 (no ROM), the register reads zero after any write, including all-ones, and no request is ever claimed.
- R12: One clock after a cycle with a request, exactly one of `rom_hit` and `req_unclaimed` is 1. One clock after a cycle without a request, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe for the register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current register value |
| mem_space_en | input | 1 | Memory Space Enable from the command register |
| req_valid | input | 1 | Request present this cycle |
| req_is_write | input | 1 | 1 = memory write, 0 = memory read |
| req_addr | input | 64 | Request byte address |
| rom_hit | output | 1 | Previous-cycle request claimed by the ROM window |
| req_unclaimed | output | 1 | Previous-cycle request not claimed |

## Verification
Directed probes cover the following cases:
- all-ones and all-zero writes, which separate the hardwired size marker from the writable field;
- the first and last byte of the window, and the bytes just outside it, which expose an off-by-one in the compare width;
- requests that break one condition at a time (write type, high address bits, either enable), which show that each condition alone blocks a claim.

A seeded random mix then interleaves register writes with random base and enable values, toggles of Memory Space Enable, and reads and writes spread across three window-sized spans around the base, some with high bits set. A second instance with no ROM checks that the register always reads zero and never claims.

// File: rtl/exp_rom_bar_pkg.sv
package exp_rom_bar_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_HIT  = 2'd1,
        RSP_MISS = 2'd2
    } rsp_state_e;

    // Bits that software may change: decode enable plus base bits above the size marker.
    function automatic logic [31:0] writable_bits(input int unsigned rom_bytes);
        logic [31:0] m;
        if (rom_bytes == 0) begin
            m = 32'h0;
        end else begin
            m = (~(rom_bytes - 32'd1)) & 32'hFFFF_F800;
            m[0] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/exp_rom_bar_reg.sv
module exp_rom_bar_reg #(
    parameter int unsigned ROM_BYTES = 32'h0001_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] value
);
    import exp_rom_bar_pkg::*;

    localparam logic [31:0] WMASK = writable_bits(ROM_BYTES);

    logic [31:0] reg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= 32'h0;
        end else if (wr_en) begin
            reg_q <= wdata & WMASK;
        end
    end

    assign value = reg_q;

    // R2: size marker bits never read as one
    p_marker_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        value[10:1] == 10'h0);

endmodule

// File: rtl/exp_rom_bar_match.sv
module exp_rom_bar_match #(
    parameter int unsigned ROM_BYTES = 32'h0001_0000
) (
    input  logic [31:0] bar_value,
    input  logic        mem_space_en,
    input  logic        req_is_write,
    input  logic [63:0] req_addr,
    output logic        claim
);
    import exp_rom_bar_pkg::*;

    localparam logic [31:0] WMASK     = writable_bits(ROM_BYTES);
    localparam logic [31:0] ADDR_MASK = WMASK & 32'hFFFF_FFFE;

    generate
        if (ROM_BYTES == 0) begin : g_absent
            assign claim = 1'b0;
        end else begin : g_present
            logic in_low4g;
            logic in_window;
            assign in_low4g  = (req_addr[63:32] == 32'h0);
            assign in_window = (((req_addr[31:0] ^ bar_value) & ADDR_MASK) == 32'h0);
            assign claim     = bar_value[0] & mem_space_en & ~req_is_write
                               & in_low4g & in_window;
        end
    endgenerate

endmodule

// File: rtl/exp_rom_bar_ctrl.sv
module exp_rom_bar_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic claim,
    output logic rom_hit,
    output logic req_unclaimed
);
    import exp_rom_bar_pkg::*;

    rsp_state_e st_q;
    rsp_state_e st_d;

    always_comb begin
        st_d = RSP_IDLE;
        unique case (st_q)
            RSP_IDLE, RSP_HIT, RSP_MISS: begin
                if (req_valid) begin
                    st_d = claim ? RSP_HIT : RSP_MISS;
                end
            end
            default: st_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= RSP_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rom_hit       = 1'b0;
        req_unclaimed = 1'b0;
        unique case (st_q)
            RSP_IDLE: ;
            RSP_HIT:  rom_hit = 1'b1;
            RSP_MISS: req_unclaimed = 1'b1;
            default:  ;
        endcase
    end

    // R12: a single answer per request, silence otherwise
    p_one_answer_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_hit && req_unclaimed));
    p_answer_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rom_hit || req_unclaimed));
    p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rom_hit && !req_unclaimed));
    // R5: a claimed request is reported as a hit next cycle
    p_claim_hits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && claim) |=> rom_hit);

endmodule

// File: rtl/exp_rom_bar.sv
module exp_rom_bar #(
    parameter int unsigned ROM_BYTES = 32'h0001_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        mem_space_en,
    input  logic        req_valid,
    input  logic        req_is_write,
    input  logic [63:0] req_addr,
    output logic        rom_hit,
    output logic        req_unclaimed
);

    logic [31:0] bar_value;
    logic        claim;

    exp_rom_bar_reg #(.ROM_BYTES(ROM_BYTES)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .wdata (cfg_wdata),
        .value (bar_value)
    );

    exp_rom_bar_match #(.ROM_BYTES(ROM_BYTES)) u_match (
        .bar_value    (bar_value),
        .mem_space_en (mem_space_en),
        .req_is_write (req_is_write),
        .req_addr     (req_addr),
        .claim        (claim)
    );

    exp_rom_bar_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .claim         (claim),
        .rom_hit       (rom_hit),
        .req_unclaimed (req_unclaimed)
    );

    assign cfg_rdata = bar_value;

    // R9: writes are never claimed
    p_write_no_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_write) |=> !rom_hit);
    // R8: addresses above 4 GB are never claimed
    p_high_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[63:32] != 32'h0)) |=> !rom_hit);
    // R7: Memory Space Enable gates decode
    p_mse_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_space_en) |=> !rom_hit);
    // R6: the register's own enable gates decode
    p_rom_en_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cfg_rdata[0]) |=> !rom_hit);

endmodule

// File: tb/tb_exp_rom_bar.sv
`timescale 1ns/1ps
module tb_exp_rom_bar;

    localparam int unsigned ROM_BYTES = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = 32'h0;
    logic        mem_space_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_write = 1'b0;
    logic [63:0] req_addr = 64'h0;
    logic [31:0] cfg_rdata, none_rdata;
    logic        rom_hit, req_unclaimed, none_hit, none_unclaimed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model_q = 32'h0;

    always #2.5 clk = ~clk;

    exp_rom_bar #(.ROM_BYTES(ROM_BYTES)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .mem_space_en(mem_space_en), .req_valid(req_valid),
        .req_is_write(req_is_write), .req_addr(req_addr), .rom_hit(rom_hit),
        .req_unclaimed(req_unclaimed));

    exp_rom_bar #(.ROM_BYTES(0)) dut_none (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(none_rdata), .mem_space_en(mem_space_en), .req_valid(req_valid),
        .req_is_write(req_is_write), .req_addr(req_addr), .rom_hit(none_hit),
        .req_unclaimed(none_unclaimed));

    function automatic logic [31:0] bench_mask();
        logic [31:0] m = 32'h1;
        for (int b = 11; b < 32; b++) begin
            if ((64'd1 << b) >= 64'(ROM_BYTES)) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic expect_hit(input logic [63:0] a, input logic wr);
        logic [31:0] am = bench_mask() & 32'hFFFF_FFFE;
        return model_q[0] && mem_space_en && !wr && (a[63:32] == 32'h0)
               && ((a[31:0] & am) == (model_q & am));
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] d, input string tag);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        model_q = d & bench_mask();
        check(tag, 64'(cfg_rdata), 64'(model_q));
        check("R11 absent register", 64'(none_rdata), 64'h0);
    endtask

    task automatic do_req(input logic [63:0] a, input logic wr, input string tag);
        logic e;
        @(negedge clk);
        req_valid = 1'b1;
        req_is_write = wr;
        req_addr = a;
        e = expect_hit(a, wr);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {62'h0, rom_hit, req_unclaimed}, {62'h0, e, ~e});
        check("R11 absent never claims", {62'h0, none_hit, none_unclaimed}, {62'h0, 2'b01});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] base;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 reset rdata", 64'(cfg_rdata), 64'h0);
        check("R1 reset outputs", {62'h0, rom_hit, req_unclaimed}, 64'h0);

        // R2 R3 R4: sizing pattern
        cfg_write(32'hFFFF_FFFF, "R2 all-ones readback");
        check("R2 size marker", 64'(cfg_rdata), 64'hFFFF_0001);
        cfg_write(32'h0000_07FE, "R2 marker bits stay zero");
        cfg_write(32'hC000_0001, "R3 R4 base and enable");
        check("R4 base field", 64'(cfg_rdata & 32'hFFFF_0000), 64'hC000_0000);
        check("R3 enable bit", 64'(cfg_rdata[0]), 64'h1);

        // R12 idle
        @(negedge clk);
        check("R12 idle quiet", {62'h0, rom_hit, req_unclaimed}, 64'h0);

        mem_space_en = 1'b1;
        do_req(64'hC000_0000, 1'b0, "R5 hit at base");
        check("R5 hit one cycle", 64'(rom_hit), 64'h1);
        do_req(64'hC000_FFFF, 1'b0, "R10 last byte hits");
        do_req(64'hC001_0000, 1'b0, "R10 past end misses");
        do_req(64'hBFFF_FFFF, 1'b0, "R10 below base misses");
        do_req(64'hC000_0100, 1'b1, "R9 write unclaimed");
        do_req(64'h0000_0001_C000_0100, 1'b0, "R8 high address misses");
        mem_space_en = 1'b0;
        do_req(64'hC000_0100, 1'b0, "R7 mse off misses");
        mem_space_en = 1'b1;
        cfg_write(32'hC000_0000, "R6 enable cleared");
        do_req(64'hC000_0100, 1'b0, "R6 rom disabled misses");
        @(negedge clk);
        check("R12 idle after request", {62'h0, rom_hit, req_unclaimed}, 64'h0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned op = $urandom % 8;
            if (op == 0) begin
                cfg_write($urandom, "R4 random write");
            end else if (op == 1) begin
                @(negedge clk);
                mem_space_en = ~mem_space_en;
            end else begin
                logic [63:0] a;
                base = model_q & 32'hFFFF_FFFE;
                a[31:0] = base - ROM_BYTES + ($urandom % (3 * ROM_BYTES));
                a[63:32] = (($urandom % 8) == 0) ? 32'($urandom) : 32'h0;
                do_req(a, (($urandom % 4) == 0), "R5 random request");
            end
        end
        finish_run();
    end

endmodule